// File: doc/BRIEF.md
# Switchable-Depth Receive Byte Buffer

This block holds the characters a serial receiver has assembled until the host reads them from the data register. It runs in one of two depths. In the legacy depth it is a single holding byte. In the queued depth it is a sixteen-entry first-in first-out buffer. The host chooses the depth through writes to an 8-bit control word. The same word can also order the buffer to be emptied.

Bytes enter on a push strobe, which comes either from the deserializer or from the loopback path. They leave on a pop strobe raised by a data-register read; the byte at the head is presented combinationally during that cycle. When a push meets a full buffer, the byte is dropped and a one-cycle overrun pulse is raised. The outputs are the occupancy count, a data-ready flag and the stored control word, which later stages decode for trigger level and DMA mode.

Top module: `uart_rx_store`

## Requirements
- R1: After reset, `level` is 0, `data_rdy` is 0, `cfg_q` is 0x00, `ovr_pulse` is 0 and the capacity is 1 byte.
- R2: While `cfg_q` bit 0 is 0, the capacity is 1 byte: a second push with no pop in between is rejected.
- R3: While `cfg_q` bit 0 is 1, the capacity is 16 bytes: 16 pushes are accepted and the 17th is rejected.
- R4: A control write whose bit 0 differs from `cfg_q` bit 0 empties the buffer and sets the new capacity. A control write that leaves bit 0 unchanged and has bit 1 clear keeps the stored bytes.
- R5: A control write with bit 0 clear sets `cfg_q` to 0x00, whatever its other bits are.
- R6: A control write with bit 0 set stores only bits 0, 3, 6 and 7 of the written value; `cfg_q` becomes the written value AND 0xC9.
- R7: A control write with bit 0 set and bit 1 set empties the buffer and leaves the capacity at 16.
- R8: A push while `level` equals the capacity does not store its byte, leaves the stored bytes unchanged, and sets `ovr_pulse` high for exactly the following cycle.
- R9: A pop while `level` is 0 gives `pop_vld` 0 and `pop_byte` 0x00 and leaves `level` unchanged.
- R10: Bytes leave in the order they were pushed, including when the read and write positions wrap past the last entry. While `level` is non-zero, `pop_byte` shows the oldest byte.
- R11: A push and a pop in the same cycle on a non-empty buffer that is below capacity leave `level` unchanged. At capacity, the push is judged against the count before the pop, so it is rejected with an overrun and `level` drops by one.
- R12: `data_rdy` is 1 exactly when `level` is non-zero.
- R13: In a cycle where a control write empties the buffer, a push or pop in the same cycle is discarded: `pop_vld` is 0, `level` ends at 0 and no overrun is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_vld | input | 1 | Offer `push_byte` for storage this cycle |
| push_byte | input | DATA_W | Received character |
| pop_req | input | 1 | Data-register read: remove the head byte |
| pop_vld | output | 1 | The pop this cycle removes a real byte |
| pop_byte | output | DATA_W | Head byte while non-empty, else zero |
| cfg_wr | input | 1 | Control-word write strobe |
| cfg_wdata | input | 8 | Control-word write value |
| cfg_q | output | 8 | Stored control word |
| data_rdy | output | 1 | At least one byte is held |
| ovr_pulse | output | 1 | One-cycle pulse after a rejected push |
| level | output | $clog2(DEPTH+1) | Number of bytes held |

## Verification
Three actions can fall in the same clock: a push, a pop and a control write. The bench provokes each pairing deliberately. It pushes and pops together below capacity and at capacity in both depths, and it writes an emptying control word in the same cycle as a push and a pop. A behavioural queue model applies the stated rules to every cycle: the full check uses the count before the pop, and an emptying write overrides both strobes. The comparison covers `pop_vld` and `pop_byte` in mid-cycle, and `level`, `data_rdy`, `cfg_q` and `ovr_pulse` after each edge. A randomized stretch then mixes all three actions.

// File: rtl/rxq_pkg.sv
// rxq_pkg: control-word bit positions and the mode bundle shared by the
// receive buffer modules. Assumes an 8-bit control word.
package rxq_pkg;

    localparam int unsigned CFG_W        = 8;
    localparam int unsigned CFG_EN_BIT   = 0;  // selects the deep mode
    localparam int unsigned CFG_RRST_BIT = 1;  // empties the buffer when set with EN
    localparam int unsigned CFG_DMA_BIT  = 3;  // kept for the DMA stage
    localparam int unsigned CFG_TRIG_LO  = 6;  // trigger field low bit
    localparam int unsigned CFG_TRIG_HI  = 7;  // trigger field high bit

    // Bits that survive a write with EN set.
    localparam logic [CFG_W-1:0] CFG_KEEP =
        (CFG_W'(1) << CFG_EN_BIT)  | (CFG_W'(1) << CFG_DMA_BIT) |
        (CFG_W'(1) << CFG_TRIG_LO) | (CFG_W'(1) << CFG_TRIG_HI);

    // Mode information from the control register to the storage.
    typedef struct packed {
        logic wide;   // deep capacity selected
        logic flush;  // empty the buffer at the coming edge
    } rxq_mode_t;

endpackage

// File: rtl/rxq_cfg_reg.sv
// rxq_cfg_reg: holds the control word and decodes each write.
// A write that flips EN, or that sets EN together with the receive-reset
// bit, raises flush in the same cycle. With EN clear, the whole word is
// cleared. With EN set, only the CFG_KEEP bits are stored.
// Assumes: synchronous active-low reset; flush is combinational from the write.
module rxq_cfg_reg
    import rxq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output logic [CFG_W-1:0] cfg_q,
    output rxq_mode_t        mode
);

    logic [CFG_W-1:0] cfg_d;
    logic             en_flip;
    logic             rx_reset;

    // Decode the write into the next word and the flush request.
    always_comb begin
        en_flip  = wr_en && (wr_data[CFG_EN_BIT] != cfg_q[CFG_EN_BIT]);
        rx_reset = wr_en && wr_data[CFG_EN_BIT] && wr_data[CFG_RRST_BIT];
        cfg_d    = cfg_q;
        if (wr_en) begin
            cfg_d = wr_data[CFG_EN_BIT] ? (wr_data & CFG_KEEP) : '0;
        end
        mode.flush = en_flip || rx_reset;
        mode.wide  = cfg_q[CFG_EN_BIT];
    end

    // Control word register.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    // R5: a write with EN clear leaves the word at zero.
    p_cfg_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[CFG_EN_BIT]) |=> (cfg_q == '0));

    // R6: a write with EN set keeps only the selected bits.
    p_cfg_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[CFG_EN_BIT]) |=> (cfg_q == ($past(wr_data) & CFG_KEEP)));

    // R6: without a write, the word holds.
    p_cfg_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_q));

endmodule

// File: rtl/rxq_ring.sv
// rxq_ring: circular byte store whose capacity is 1 or DEPTH, chosen by mode.wide.
// The pointers wrap at the current capacity. The count runs from 0 to capacity.
// The full check uses the count before any pop in the same cycle. Flush wins
// over push and pop in its cycle. The overrun pulse is registered: it is high
// in the cycle after the rejected push.
// Assumes: a change of wide always comes with a flush, so the pointers are
// zero when the capacity shrinks. The slots are not reset, because the
// output is gated by the count.
module rxq_ring
    import rxq_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 16,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  rxq_mode_t         mode,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic              pop_ok,
    output logic [DATA_W-1:0] head_data,
    output logic [CNT_W-1:0]  count,
    output logic              ovr
);

    logic [PTR_W-1:0]                 wptr, rptr, lim;
    logic [CNT_W-1:0]                 cap;
    logic                             full, empty, do_push, do_pop;
    logic [DEPTH-1:0][DATA_W-1:0]     slots;

    // Current capacity and last pointer index.
    always_comb begin
        cap     = mode.wide ? CNT_W'(DEPTH) : CNT_W'(1);
        lim     = mode.wide ? PTR_W'(DEPTH - 1) : '0;
        full    = (count == cap);
        empty   = (count == '0);
        do_push = push && !full && !mode.flush;
        do_pop  = pop && !empty && !mode.flush;
    end

    // Storage slots, each written when selected by the write pointer.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [DATA_W-1:0] slot_q;
        // Capture the pushed byte into this slot.
        always_ff @(posedge clk) begin
            if (do_push && (wptr == PTR_W'(i))) slot_q <= push_data;
        end
        assign slots[i] = slot_q;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n || mode.flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= (wptr == lim) ? '0 : wptr + PTR_W'(1);
            if (do_pop)  rptr <= (rptr == lim) ? '0 : rptr + PTR_W'(1);
            case ({do_push, do_pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

    // Overrun pulse, one cycle after the rejected push.
    always_ff @(posedge clk) begin
        if (!rst_n) ovr <= 1'b0;
        else        ovr <= push && full && !mode.flush;
    end

    assign pop_ok    = do_pop;
    assign head_data = empty ? '0 : slots[rptr];

    // R2/R3: occupancy never exceeds the active capacity.
    p_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= cap);

    // R4: a flush leaves the buffer empty.
    p_flush_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mode.flush |=> (count == '0));

    // R8: a push into a full buffer does not grow it and raises the overrun.
    p_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !mode.flush) |=> (ovr && count == $past(count)));

    // R9: a lone pop of an empty buffer changes nothing.
    p_empty_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push && !mode.flush) |=> (count == '0));

    // R11: push and pop together below capacity keep the count.
    p_pair_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !empty && !full && !mode.flush) |=> (count == $past(count)));

    // R13: a flush cycle raises no overrun.
    p_flush_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
        mode.flush |=> !ovr);

endmodule

// File: rtl/uart_rx_store.sv
// uart_rx_store: receive character buffer with a run-time depth of 1 or DEPTH.
// The control register picks the depth and requests flushes; the ring holds
// the bytes. Assumes: at most one push and one pop per cycle; synchronous
// active-low reset.
module uart_rx_store
    import rxq_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push_vld,
    input  logic [DATA_W-1:0]          push_byte,
    input  logic                       pop_req,
    output logic                       pop_vld,
    output logic [DATA_W-1:0]          pop_byte,
    input  logic                       cfg_wr,
    input  logic [7:0]                 cfg_wdata,
    output logic [7:0]                 cfg_q,
    output logic                       data_rdy,
    output logic                       ovr_pulse,
    output logic [$clog2(DEPTH+1)-1:0] level
);

    rxq_mode_t mode;

    rxq_cfg_reg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr),
        .wr_data (cfg_wdata),
        .cfg_q   (cfg_q),
        .mode    (mode)
    );

    rxq_ring #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .push      (push_vld),
        .push_data (push_byte),
        .pop       (pop_req),
        .pop_ok    (pop_vld),
        .head_data (pop_byte),
        .count     (level),
        .ovr       (ovr_pulse)
    );

    // Ready whenever anything is held.
    assign data_rdy = (level != '0);

    // R9/R12: a valid pop needs a ready buffer.
    p_pop_needs_rdy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        pop_vld |-> data_rdy);

endmodule

// File: tb/uart_rx_store_tb.sv
module uart_rx_store_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       push_vld, pop_req, cfg_wr;
    logic [7:0] push_byte, cfg_wdata;
    logic       pop_vld, data_rdy, ovr_pulse;
    logic [7:0] pop_byte, cfg_q;
    logic [4:0] level;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    // Reference model
    logic [7:0] mq[$];
    int         mcap;
    logic [7:0] mfcr;
    bit         movr;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_rx_store #(.DATA_W(8), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .push_vld(push_vld), .push_byte(push_byte),
        .pop_req(pop_req), .pop_vld(pop_vld), .pop_byte(pop_byte),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q),
        .data_rdy(data_rdy), .ovr_pulse(ovr_pulse), .level(level)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic check_regs(input string tag);
        chk(tag, "level", int'(level), mq.size());
        chk(tag, "data_rdy R12", int'(data_rdy), int'(mq.size() != 0));
        chk(tag, "cfg_q", int'(cfg_q), int'(mfcr));
        chk(tag, "ovr_pulse", int'(ovr_pulse), int'(movr));
    endtask

    // One cycle: entered and left at a falling edge.
    task automatic step(input bit psh, input logic [7:0] pb, input bit pp,
                        input bit wr, input logic [7:0] wd, input string tag);
        bit flush, full;
        push_vld = psh; push_byte = pb; pop_req = pp; cfg_wr = wr; cfg_wdata = wd;
        #1;
        flush = wr && ((wd[0] != mfcr[0]) || (wd[0] && wd[1]));
        full  = (mq.size() == mcap);
        chk(tag, "pop_vld", int'(pop_vld), int'(pp && mq.size() != 0 && !flush));
        chk(tag, "pop_byte", int'(pop_byte), (mq.size() != 0) ? int'(mq[0]) : 0);
        movr = psh && full && !flush;
        if (flush) mq.delete();
        else begin
            if (pp && mq.size() != 0) void'(mq.pop_front());
            if (psh && !full) mq.push_back(pb);
        end
        if (wr) begin
            mfcr = wd[0] ? (wd & 8'hC9) : 8'h00;
            mcap = mfcr[0] ? DEPTH : 1;
        end
        @(posedge clk);
        @(negedge clk);
        push_vld = 0; pop_req = 0; cfg_wr = 0;
        check_regs(tag);
    endtask

    initial begin
        rst_n = 0; push_vld = 0; pop_req = 0; cfg_wr = 0; push_byte = 0; cfg_wdata = 0;
        mcap = 1; mfcr = 0; movr = 0;
        repeat (3) @(posedge clk);
        rst_n = 1;
        @(negedge clk);
        check_regs("R1");
        // R1/R2: legacy depth of one
        step(1, 8'hA1, 0, 0, 0, "R2");
        step(1, 8'hB2, 0, 0, 0, "R2");    // rejected: R8 overrun
        step(0, 0, 0, 0, 0, "R8");        // pulse gone after one cycle
        step(1, 8'hC3, 1, 0, 0, "R11");   // at capacity: push rejected, pop taken
        step(0, 0, 1, 0, 0, "R10");
        step(0, 0, 1, 0, 0, "R9");        // pop of empty
        // R4/R5: write keeping EN clear keeps contents, clears word
        step(1, 8'h5A, 0, 0, 0, "R4");
        step(0, 0, 0, 1, 8'hFE, "R5");
        // R4/R6: enable flips -> flush, masked word
        step(0, 0, 0, 1, 8'hCD, "R6");
        // R3: fill sixteen, seventeenth rejected
        for (int i = 0; i < DEPTH; i++) step(1, 8'(8'h10 + i), 0, 0, 0, "R3");
        step(1, 8'hEE, 0, 0, 0, "R3");
        step(1, 8'hEF, 1, 0, 0, "R11");   // full: reject push, take pop
        for (int i = 0; i < 6; i++) step(0, 0, 1, 0, 0, "R10");
        for (int i = 0; i < 12; i++) step(1, 8'(8'h80 + i), 1, 0, 0, "R10"); // wrap
        step(1, 8'h99, 1, 0, 0, "R11");
        for (int i = 0; i < 10; i++) step(0, 0, 1, 0, 0, "R10");
        // R7: receive reset in deep mode
        step(1, 8'h31, 0, 0, 0, "R7");
        step(1, 8'h32, 0, 0, 0, "R7");
        step(0, 0, 0, 1, 8'h4B, "R7");
        step(1, 8'h33, 0, 0, 0, "R7");
        step(0, 0, 0, 1, 8'h41, "R4");    // EN kept, no reset: contents stay
        step(1, 8'h34, 0, 0, 0, "R4");
        // R13: emptying write overrides push and pop
        step(1, 8'h35, 1, 1, 8'h00, "R13");
        step(1, 8'h36, 0, 0, 0, "R2");
        step(1, 8'h37, 1, 1, 8'h01, "R13");
        step(1, 8'h38, 0, 0, 0, "R3");
        // Mixed random stretch
        for (int i = 0; i < 400; i++) begin
            bit w;
            w = ($urandom % 16) == 0;
            step(bit'($urandom % 2), 8'($urandom), bit'($urandom % 3 == 0),
                 w, 8'($urandom), "R10");
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule